// File: doc/BRIEF.md
# I2C Register Access Target

This block is an I2C target that lets an external bus controller read and write a bank of 16-bit registers. SCL and SDA come in asynchronously and are resynchronized onto a fast system clock, at least eight times the SCL rate. START, repeated START and STOP conditions and SCL edges are detected on that clock. SDA is driven only as an open-drain pull-down enable.

A write transaction carries the target address, then one pointer byte, then any number of two-byte words. The pointer byte holds a 7-bit register address in its low bits and a block-access flag in bit 7. The stored pointer persists across transactions. A read transaction starts returning words from the stored pointer. With the block flag set, consecutive words go to consecutive registers and stop advancing at the top address. Without the flag, every word of a transaction uses the same register.

On the register side there is a plain synchronous port: an address, write data, a one-cycle write strobe, and read data that the bank returns registered one clock after the address.

Top module: `i2c_reg_target`

## Requirements
- R1: The target ACKs an address byte whose upper seven bits equal TARGET_ADDR (default 0x4A). For any other address it ACKs nothing and keeps SDA released until the next START.
- R2: In a write transaction, the first byte after the address byte is loaded as the register pointer. The target ACKs that byte and every following data byte.
- R3: A write transaction that ends after the pointer byte changes the pointer and issues no register write.
- R4: A read transaction returns the register selected by the stored pointer. The pointer survives STOP, repeated START and non-matching transactions, so repeated reads return the same register.
- R5: Each register moves as two bytes, most significant byte first, and each byte most significant bit first.
- R6: After the controller NACKs a read byte, the target releases SDA and drives nothing until the next START or STOP.
- R7: When pointer bit 7 is 1 (block access), word k of a transaction accesses pointer+k. Every transaction starts again from the stored pointer.
- R8: In block access the address stops at 0x7F, and further words of that transaction keep accessing 0x7F.
- R9: When pointer bit 7 is 0, every word of a transaction accesses the pointer address.
- R10: A register write is issued only after both bytes of a word have been received and ACKed. A word cut short by STOP is discarded.
- R11: SDA drive changes only after a detected SCL falling edge, START or STOP, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 7 | Register address (current cursor) |
| reg_wdata | output | 16 | Write data for the register bank |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 16 | Read data, valid one cycle after reg_addr |

## Verification
The bench instantiates the block with SYNC_STAGES set to 3 rather than 2, which lengthens the delay from an SCL edge to the SDA response. Running the bus with a 40-cycle SCL period therefore exercises the timing margin between the target's drive and the controller's sample point. TARGET_ADDR and DATA_W keep their defaults. With the 7-bit pointer, a block write started at 0x7E reaches the saturation address on its second word, so the clamp at 0x7F is exercised within a short transaction.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_SKIP
  } link_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_t;

  typedef struct packed {
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2cr_pin_sync.sv
module i2cr_pin_sync
  import i2cr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);

  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] prev_q;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    assign ff_d = {ff_q[STAGES-2:0], pin_raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ff_q <= '1;
      end else begin
        ff_q <= ff_d;
      end
    end

    assign pin_s[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= pin_s;
    end
  end

  // index 0 = SCL, index 1 = SDA
  always_comb begin
    ev.sda      = pin_s[1];
    ev.scl_rise = pin_s[0] & ~prev_q[0];
    ev.scl_fall = ~pin_s[0] & prev_q[0];
    ev.start    = pin_s[0] & prev_q[0] & prev_q[1] & ~pin_s[1];
    ev.stop     = pin_s[0] & prev_q[0] & ~prev_q[1] & pin_s[1];
  end

endmodule

// File: rtl/i2cr_cursor.sv
module i2cr_cursor #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic          load,
  input  logic [7:0]    load_byte,
  input  logic          adv,
  output logic [AW-1:0] cur
);

  localparam logic [AW-1:0] SAT = '1;

  logic [AW-1:0] base_q, base_d;
  logic          blk_q, blk_d;
  logic [AW-1:0] cur_q, cur_d;

  always_comb begin
    base_d = base_q;
    blk_d  = blk_q;
    cur_d  = cur_q;
    if (load) begin
      blk_d  = load_byte[7];
      base_d = load_byte[AW-1:0];
      cur_d  = load_byte[AW-1:0];
    end else if (restore) begin
      cur_d = base_q;
    end else if (adv && blk_q && (cur_q != SAT)) begin
      cur_d = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      blk_q  <= 1'b0;
      cur_q  <= '0;
    end else begin
      base_q <= base_d;
      blk_q  <= blk_d;
      cur_q  <= cur_d;
    end
  end

  assign cur = cur_q;

  // R8: a block cursor at the top address stays there
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && blk_q && !load && !restore && cur_q == SAT) |=> (cur_q == SAT));

  // R9: without block access a word never moves the cursor
  a_r9_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !blk_q && !load && !restore) |=> $stable(cur_q));

  // R7: block access moves to the next address below the top
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && blk_q && !load && !restore && cur_q != SAT) |=> (cur_q == $past(cur_q) + 1'b1));

endmodule

// File: rtl/i2cr_link.sv
module i2cr_link
  import i2cr_pkg::*;
#(
  parameter logic [6:0] TARGET = 7'h4A,
  parameter int         DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_ev_t       ev,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe,
  output logic          cur_restore,
  output logic          ptr_load,
  output logic [7:0]    ptr_byte,
  output logic          cur_adv,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata
);

  localparam int              NB   = DW / 8;
  localparam int              BIW  = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [BIW-1:0]  LAST = BIW'(NB - 1);

  link_st_t       st_q, st_d;
  phase_t         ph_q, ph_d;
  logic [3:0]     cnt_q, cnt_d;
  logic [7:0]     sh_q, sh_d;
  logic [DW-1:0]  hold_q, hold_d;
  logic [DW-1:0]  wacc_q, wacc_d;
  logic [BIW-1:0] bidx_q, bidx_d;
  logic           rd_q, rd_d;
  logic           nack_q, nack_d;
  logic           oe_q, oe_d;
  logic           fetch;
  logic [7:0]     tx_byte;

  always_comb begin
    st_d        = st_q;
    ph_d        = ph_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    hold_d      = hold_q;
    wacc_d      = wacc_q;
    bidx_d      = bidx_q;
    rd_d        = rd_q;
    nack_d      = nack_q;
    oe_d        = oe_q;
    cur_restore = 1'b0;
    ptr_load    = 1'b0;
    cur_adv     = 1'b0;
    reg_we      = 1'b0;
    fetch       = 1'b0;
    tx_byte     = 8'h00;

    if (ev.stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (ev.start) begin
      st_d        = ST_RX;
      ph_d        = PH_ADDR;
      cnt_d       = 4'd0;
      bidx_d      = '0;
      oe_d        = 1'b0;
      cur_restore = 1'b1;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (ev.scl_rise) begin
            sh_d  = {sh_q[6:0], ev.sda};
            cnt_d = cnt_q + 4'd1;
          end else if (ev.scl_fall && cnt_q == 4'd8) begin
            unique case (ph_q)
              PH_ADDR: begin
                if (sh_q[7:1] == TARGET) begin
                  st_d = ST_ACK;
                  oe_d = 1'b1;
                  rd_d = sh_q[0];
                end else begin
                  st_d = ST_SKIP;
                end
              end
              PH_PTR: begin
                st_d     = ST_ACK;
                oe_d     = 1'b1;
                ptr_load = 1'b1;
              end
              default: begin
                st_d   = ST_ACK;
                oe_d   = 1'b1;
                wacc_d = {wacc_q[DW-9:0], sh_q};
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ev.scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = 4'd0;
            unique case (ph_q)
              PH_ADDR: begin
                if (rd_q) begin
                  st_d  = ST_TX;
                  fetch = 1'b1;
                end else begin
                  st_d = ST_RX;
                  ph_d = PH_PTR;
                end
              end
              PH_PTR: begin
                st_d   = ST_RX;
                ph_d   = PH_DATA;
                bidx_d = '0;
              end
              default: begin
                st_d = ST_RX;
                if (bidx_q == LAST) begin
                  reg_we  = 1'b1;
                  cur_adv = 1'b1;
                  bidx_d  = '0;
                end else begin
                  bidx_d = bidx_q + 1'b1;
                end
              end
            endcase
          end
        end
        ST_TX: begin
          if (ev.scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d = 1'b0;
              st_d = ST_RACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (ev.scl_rise) begin
            nack_d = ev.sda;
          end else if (ev.scl_fall) begin
            if (nack_q) begin
              st_d = ST_SKIP;
            end else begin
              st_d  = ST_TX;
              fetch = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

    if (fetch) begin
      if (bidx_q == '0) begin
        tx_byte = rdata[DW-1 -: 8];
        hold_d  = rdata << 8;
        cur_adv = 1'b1;
      end else begin
        tx_byte = hold_q[DW-1 -: 8];
        hold_d  = hold_q << 8;
      end
      sh_d   = tx_byte;
      oe_d   = ~tx_byte[7];
      cnt_d  = 4'd0;
      bidx_d = (bidx_q == LAST) ? '0 : bidx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      cnt_q  <= 4'd0;
      sh_q   <= 8'h00;
      hold_q <= '0;
      wacc_q <= '0;
      bidx_q <= '0;
      rd_q   <= 1'b0;
      nack_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      hold_q <= hold_d;
      wacc_q <= wacc_d;
      bidx_q <= bidx_d;
      rd_q   <= rd_d;
      nack_q <= nack_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign ptr_byte  = sh_q;
  assign reg_wdata = wacc_q;

  // R1: an address ACK is only ever given to the own address
  a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) && st_q == ST_ACK && ph_q == PH_ADDR) |-> (sh_q[7:1] == TARGET));

  // R6: once skipping, SDA stays released
  a_r6_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !oe_q);

  // R5: while sending, the line carries the MSB of the shift register
  a_r5_msb_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX) |-> (oe_q == !sh_q[7]));

  // R11: drive changes only follow an SCL fall, START or STOP
  a_r11_oe_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> $past(ev.scl_fall || ev.start || ev.stop));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2cr_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h4A,
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [6:0]        reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int AW = 7;

  bus_ev_t       ev;
  logic          cur_restore;
  logic          ptr_load;
  logic [7:0]    ptr_byte;
  logic          cur_adv;
  logic [AW-1:0] cur;

  i2cr_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  i2cr_link #(
    .TARGET (TARGET_ADDR),
    .DW     (DATA_W)
  ) u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .rdata       (reg_rdata),
    .sda_oe      (sda_oe),
    .cur_restore (cur_restore),
    .ptr_load    (ptr_load),
    .ptr_byte    (ptr_byte),
    .cur_adv     (cur_adv),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata)
  );

  i2cr_cursor #(
    .AW (AW)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .restore   (cur_restore),
    .load      (ptr_load),
    .load_byte (ptr_byte),
    .adv       (cur_adv),
    .cur       (cur)
  );

  assign reg_addr = cur;

endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;

  localparam int         Q     = 10;
  localparam logic [6:0] TADDR = 7'h4A;

  logic        clk;
  logic        rst_n;
  logic        m_scl;
  logic        m_low;
  logic        sda_oe;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;
  logic        sda_line;

  assign sda_line = !(m_low || sda_oe);

  i2c_reg_target #(
    .TARGET_ADDR (TADDR),
    .SYNC_STAGES (3),
    .DATA_W      (16)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // register bank seen by the block
  logic [15:0] mem [128];
  logic [15:0] model [128];

  function automatic logic [15:0] init_val(input int a);
    return {1'b0, 7'(a), 8'h5A ^ 8'(a)};
  endfunction

  always @(posedge clk) begin
    reg_rdata <= mem[reg_addr];
    if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0]  exp_rd[$];
  string       exp_rd_tag[$];
  logic [7:0]  got_rd[$];
  logic [22:0] exp_wr[$];
  string       exp_wr_tag[$];

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R3 R10 unexpected write", {9'd0, reg_addr, reg_wdata}, 32'h0);
      end else begin
        logic [22:0] e;
        string t;
        e = exp_wr.pop_front();
        t = exp_wr_tag.pop_front();
        chk({reg_addr, reg_wdata} == e, t, {9'd0, reg_addr, reg_wdata}, {9'd0, e});
      end
    end
    if (got_rd.size() > 0 && exp_rd.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_rd.pop_front();
      e = exp_rd.pop_front();
      t = exp_rd_tag.pop_front();
      chk(g == e, t, {24'd0, g}, {24'd0, e});
    end
  end

  // SDA drive must not change while SCL is high (R11); quiet windows (R6, R1)
  logic oe_prev;
  bit   r11_bad;
  bit   watch;
  bit   quiet_bad;
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe !== oe_prev)) r11_bad = 1'b1;
    if (watch && sda_oe) quiet_bad = 1'b1;
    oe_prev = sda_oe;
  end

  // bus controller primitives
  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    m_low = 1'b1; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    m_low = 1'b0; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; wq(1);
      m_scl = 1'b1;  wq(2);
      m_scl = 1'b0;  wq(1);
    end
    m_low = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    ack = !sda_line; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wq(1);
      m_scl = 1'b1; wq(1);
      b = {b[6:0], sda_line}; wq(1);
      m_scl = 1'b0;
    end
    wq(1);
    m_low = give_ack; wq(1);
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq(1);
    m_low = 1'b0;
  endtask

  // driver tasks
  logic [15:0] wbuf [4];
  logic [7:0]  bptr;

  task automatic do_write(input logic [7:0] ptr, input int n, input string tag);
    bit ack;
    logic [6:0] a;
    a = ptr[6:0];
    bptr = ptr;
    bus_start();
    send_byte({TADDR, 1'b0}, ack); chk(ack, "R1 address ack", 32'(ack), 32'd1);
    send_byte(ptr, ack);           chk(ack, "R2 pointer ack", 32'(ack), 32'd1);
    for (int k = 0; k < n; k++) begin
      exp_wr.push_back({a, wbuf[k]});
      exp_wr_tag.push_back(tag);
      model[a] = wbuf[k];
      send_byte(wbuf[k][15:8], ack); chk(ack, "R2 data ack hi", 32'(ack), 32'd1);
      send_byte(wbuf[k][7:0], ack);  chk(ack, "R2 data ack lo", 32'(ack), 32'd1);
      if (ptr[7] && a != 7'h7F) a = a + 7'd1;
    end
    bus_stop();
    wq(2);
  endtask

  task automatic do_read(input bit set_ptr, input logic [7:0] ptr, input int n, input string tag);
    bit ack;
    logic [6:0] a;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      bptr = ptr;
      send_byte({TADDR, 1'b0}, ack); chk(ack, "R1 address ack", 32'(ack), 32'd1);
      send_byte(ptr, ack);           chk(ack, "R2 pointer ack", 32'(ack), 32'd1);
      bus_start();
    end
    a = bptr[6:0];
    send_byte({TADDR, 1'b1}, ack); chk(ack, "R1 read address ack", 32'(ack), 32'd1);
    for (int k = 0; k < n; k++) begin
      exp_rd.push_back(model[a][15:8]); exp_rd_tag.push_back(tag);
      exp_rd.push_back(model[a][7:0]);  exp_rd_tag.push_back(tag);
      recv_byte(1'b1, b);           got_rd.push_back(b);
      recv_byte(k != n - 1, b);     got_rd.push_back(b);
      if (bptr[7] && a != 7'h7F) a = a + 7'd1;
    end
    quiet_bad = 1'b0;
    watch = 1'b1;
    wq(4);
    watch = 1'b0;
    chk(!quiet_bad, "R6 released after NACK", 32'(quiet_bad), 32'd0);
    bus_stop();
    wq(2);
  endtask

  initial begin
    m_scl = 1'b1;
    m_low = 1'b0;
    watch = 1'b0;
    quiet_bad = 1'b0;
    r11_bad = 1'b0;
    oe_prev = 1'b0;
    bptr = 8'h00;
    for (int i = 0; i < 128; i++) begin
      mem[i]   = init_val(i);
      model[i] = init_val(i);
    end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R11 reset state", {30'd0, sda_oe, reg_we}, 32'd0);

    // single write then reads (R2, R4, R5)
    wbuf[0] = 16'hA1B2;
    do_write(8'h05, 1, "R2 single write");
    do_read(1'b1, 8'h05, 1, "R5 big-endian read");
    do_read(1'b0, 8'h00, 1, "R4 repeated read");

    // pointer-only write (R3)
    do_write(8'h10, 0, "R3");
    do_read(1'b0, 8'h00, 1, "R3 pointer-only then read");

    // block write and read (R7)
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
    do_write(8'hA0, 3, "R7 block write");
    do_read(1'b1, 8'hA0, 3, "R7 block read");
    do_read(1'b0, 8'h00, 2, "R7 block read restarts at base");

    // saturation at the top (R8)
    wbuf[0] = 16'hC0DE; wbuf[1] = 16'hBEEF; wbuf[2] = 16'h7F7F;
    do_write(8'hFE, 3, "R8 saturating write");
    do_read(1'b1, 8'hFE, 3, "R8 saturating read");

    // non-block multiword (R9)
    wbuf[0] = 16'h0F0F; wbuf[1] = 16'h9876;
    do_write(8'h30, 2, "R9 same register write");
    do_read(1'b1, 8'h30, 2, "R9 same register read");

    // truncated word (R10)
    begin
      bit ack;
      bus_start();
      send_byte({TADDR, 1'b0}, ack); chk(ack, "R1 address ack", 32'(ack), 32'd1);
      send_byte(8'h40, ack);         chk(ack, "R2 pointer ack", 32'(ack), 32'd1);
      send_byte(8'hEE, ack);         chk(ack, "R10 partial byte ack", 32'(ack), 32'd1);
      bptr = 8'h40;
      bus_stop();
      wq(2);
    end
    do_read(1'b0, 8'h00, 1, "R10 truncated word discarded");

    // foreign address (R1)
    begin
      bit ack;
      quiet_bad = 1'b0;
      watch = 1'b1;
      bus_start();
      send_byte({7'h21, 1'b0}, ack); chk(!ack, "R1 foreign address not acked", 32'(ack), 32'd0);
      send_byte(8'h05, ack);         chk(!ack, "R1 foreign pointer not acked", 32'(ack), 32'd0);
      send_byte(8'h55, ack);         chk(!ack, "R1 foreign data not acked", 32'(ack), 32'd0);
      watch = 1'b0;
      chk(!quiet_bad, "R1 SDA released for foreign address", 32'(quiet_bad), 32'd0);
      bus_stop();
      wq(2);
    end
    do_read(1'b0, 8'h00, 1, "R4 pointer kept over foreign transaction");

    repeat (40) @(negedge clk);
    chk(exp_wr.size() == 0, "R10 all expected writes seen", exp_wr.size(), 0);
    chk(exp_rd.size() == 0 && got_rd.size() == 0, "R4 all read bytes compared",
        exp_rd.size() + got_rd.size(), 0);
    chk(!r11_bad, "R11 no drive change with SCL high", 32'(r11_bad), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule